// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one programmable cell of a logic fabric. Static configuration ports fill a 16-entry lookup table that takes four data lines. They also choose how the cell's single storage bit behaves. That bit can act as a plain data flop, a toggle flop, a J/K flop or a set/reset flop. The bit can also be bypassed, which turns the cell into a purely combinational function generator.

The table result can be replaced by a one-bit full-adder sum, so the cell can form one stage of a ripple carry chain. It can also be ANDed with a neighbour's result to build wide gates. The stored bit can take its clock, enable and asynchronous clear from one of two group lines each. Group-wide synchronous clear and load inputs act at the clock edge. Asynchronous preset and load inputs, together with a chip-wide active-low reset, act at once.

Top module: `logic_cell`

## Requirements
- R1: With arithmetic and cascading off and the register bypassed, `cell_out` equals bit `data_in` of `lut_mask`, with `data_in` read as an unsigned index (`data_in[0]` is the least significant index bit).
- R2: With `cfg_arith` high, the cell function is `data_in[0]` XOR `data_in[1]` XOR `carry_in`, and `carry_out` is the majority of those three. With `cfg_arith` low, `carry_out` equals `carry_in`.
- R3: With `cfg_cascade` high, `cascade_out` is the cell function ANDed with `cascade_in`. With it low, `cascade_out` is the unmodified function. The cascaded value is the one that feeds both the register and the bypass path.
- R4: In data mode (`cfg_mode` = 0), each rising edge of the selected clock loads the cell function when the enable is active. With `cfg_ena_use` high, the enable is `grp_ena[cfg_ena_sel]`; with it low, the register is always enabled. A low enable holds the stored bit.
- R5: In toggle mode (`cfg_mode` = 1), an enabled edge inverts the stored bit when the cell function is 1 and holds it when the function is 0.
- R6: In J/K mode (`cfg_mode` = 2), J is `data_in[0]` and K is `data_in[1]`. J alone sets, K alone clears, neither holds, and both toggle.
- R7: In set/reset mode (`cfg_mode` = 3), S is `data_in[0]` and R is `data_in[1]`. S alone sets and R alone clears; both high, or both low, holds.
- R8: The register is clocked only by `grp_clk[cfg_clk_sel]`. Edges on the other group clock have no effect.
- R9: `rst_n` low clears the stored bit at once. So does `grp_clr[cfg_clr_sel]` high while `cfg_clr_use` is high. The unselected clear line, or any clear line while `cfg_clr_use` is low, has no effect. Clear wins over every other control.
- R10: `async_preset` high sets the stored bit at once. `async_load` high forces the stored bit to follow `data_in[2]` at once. Preset wins over load.
- R11: `sync_clr` clears the stored bit at the selected clock edge. It wins over `sync_load` and acts even when the enable is low.
- R12: `sync_load` loads `data_in[2]` at the selected clock edge. It wins over the mode update and acts even when the enable is low.
- R13: With `cfg_bypass` high, `cell_out` is the cascaded cell function with no clock delay. With it low, `cell_out` is the stored bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lut_mask | input | 16 | Truth table of the lookup function |
| cfg_mode | input | 2 | Storage behaviour: 0 data, 1 toggle, 2 J/K, 3 set/reset |
| cfg_bypass | input | 1 | Drive the output straight from the cell function |
| cfg_arith | input | 1 | Replace the table with the full-adder sum |
| cfg_cascade | input | 1 | AND the function with `cascade_in` |
| cfg_clk_sel | input | 1 | Which group clock drives the register |
| cfg_ena_use | input | 1 | Gate updates with a group enable |
| cfg_ena_sel | input | 1 | Which group enable is used |
| cfg_clr_use | input | 1 | Allow a group clear line to clear asynchronously |
| cfg_clr_sel | input | 1 | Which group clear line is used |
| data_in | input | 4 | Four data lines into the table |
| carry_in | input | 1 | Carry from the previous cell |
| cascade_in | input | 1 | Cascade term from the previous cell |
| grp_clk | input | 2 | Group clock lines |
| grp_ena | input | 2 | Group clock enable lines |
| grp_clr | input | 2 | Group asynchronous clear lines, active high |
| sync_clr | input | 1 | Group-wide synchronous clear |
| sync_load | input | 1 | Group-wide synchronous load of `data_in[2]` |
| async_preset | input | 1 | Asynchronous preset, active high |
| async_load | input | 1 | Asynchronous load of `data_in[2]`, active high |
| rst_n | input | 1 | Chip-wide reset, active low |
| cell_out | output | 1 | Registered or bypassed cell result |
| carry_out | output | 1 | Carry to the next cell |
| cascade_out | output | 1 | Cascaded function to the next cell |

## Verification
A wrong stored bit appears on `cell_out` only while the bypass is off. It shows one selected-clock edge after the faulty update, or one delta after a faulty asynchronous action, so every register check samples just after the edge or event that should have caused it. Faults in the table, adder or cascade path appear on `cell_out`, `carry_out` and `cascade_out` in the same cycle, with no clock. Priority faults surface only when two controls are active together, so each pairing of clear, preset, load and mode update is driven with both sides asserted.

// File: rtl/logic_cell_pkg.sv
`timescale 1ns/1ps
package logic_cell_pkg;

  typedef enum logic [1:0] {
    MODE_D  = 2'd0,
    MODE_T  = 2'd1,
    MODE_JK = 2'd2,
    MODE_SR = 2'd3
  } reg_mode_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic sum3(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // Next stored value for an enabled update; j/k double as set/reset.
  function automatic logic next_q(input reg_mode_e m, input logic q,
                                  input logic x, input logic j, input logic k);
    logic nq;
    case (m)
      MODE_D:  nq = x;
      MODE_T:  nq = q ^ x;
      MODE_JK: nq = (j & k) ? ~q : (j ? 1'b1 : (k ? 1'b0 : q));
      default: nq = (j & ~k) ? 1'b1 : ((k & ~j) ? 1'b0 : q);
    endcase
    return nq;
  endfunction

endpackage

// File: rtl/lc_lut.sv
`timescale 1ns/1ps
module lc_lut
  import logic_cell_pkg::*;
#(
  parameter int LUT_INPUTS = 4,
  parameter bit HAS_ARITH  = 1'b1
) (
  input  logic [(1<<LUT_INPUTS)-1:0] lut_mask,
  input  logic [LUT_INPUTS-1:0]      data_in,
  input  logic                       carry_in,
  input  logic                       cascade_in,
  input  logic                       cfg_arith,
  input  logic                       cfg_cascade,
  output logic                       cell_fn,
  output logic                       carry_out
);

  logic table_f;
  logic stage_f;

  assign table_f = lut_mask[data_in];

  if (HAS_ARITH) begin : g_arith
    assign stage_f   = cfg_arith ? sum3(data_in[0], data_in[1], carry_in) : table_f;
    assign carry_out = cfg_arith ? maj3(data_in[0], data_in[1], carry_in) : carry_in;
  end else begin : g_plain
    assign stage_f   = table_f;
    assign carry_out = carry_in;
  end

  assign cell_fn = cfg_cascade ? (stage_f & cascade_in) : stage_f;

endmodule

// File: rtl/lc_ctrl.sv
`timescale 1ns/1ps
module lc_ctrl #(
  parameter int GRP_LINES = 2,
  parameter int SEL_W     = 1
) (
  input  logic [GRP_LINES-1:0] grp_clk,
  input  logic [GRP_LINES-1:0] grp_ena,
  input  logic [GRP_LINES-1:0] grp_clr,
  input  logic [SEL_W-1:0]     cfg_clk_sel,
  input  logic                 cfg_ena_use,
  input  logic [SEL_W-1:0]     cfg_ena_sel,
  input  logic                 cfg_clr_use,
  input  logic [SEL_W-1:0]     cfg_clr_sel,
  input  logic                 rst_n,
  input  logic                 async_preset,
  input  logic                 async_load,
  input  logic                 load_val,
  output logic                 reg_clk,
  output logic                 ena_eff,
  output logic                 aclr_eff,
  output logic                 aset_eff
);

  logic grp_clr_hit;
  logic load_hi;
  logic load_lo;

  // Configuration is static, so the clock mux never switches while running.
  assign reg_clk     = grp_clk[cfg_clk_sel];
  assign ena_eff     = cfg_ena_use ? grp_ena[cfg_ena_sel] : 1'b1;
  assign grp_clr_hit = cfg_clr_use & grp_clr[cfg_clr_sel];

  // Asynchronous load is split into a set half and a clear half.
  assign load_hi  = async_load &  load_val;
  assign load_lo  = async_load & ~load_val & ~async_preset;

  assign aclr_eff = ~rst_n | grp_clr_hit | load_lo;
  assign aset_eff = async_preset | load_hi;

endmodule

// File: rtl/lc_storage.sv
`timescale 1ns/1ps
module lc_storage
  import logic_cell_pkg::*;
(
  input  logic      clk,
  input  logic      aclr,
  input  logic      aset,
  input  logic      sync_clr,
  input  logic      sync_load,
  input  logic      load_val,
  input  logic      ena,
  input  reg_mode_e mode,
  input  logic      x,
  input  logic      j,
  input  logic      k,
  output logic      q
);

  always_ff @(posedge clk or posedge aclr or posedge aset) begin
    if (aclr)           q <= 1'b0;
    else if (aset)      q <= 1'b1;
    else if (sync_clr)  q <= 1'b0;
    else if (sync_load) q <= load_val;
    else if (ena)       q <= next_q(mode, q, x, j, k);
  end

endmodule

// File: rtl/logic_cell.sv
`timescale 1ns/1ps
module logic_cell
  import logic_cell_pkg::*;
#(
  parameter int LUT_INPUTS = 4,
  parameter int GRP_LINES  = 2,
  parameter bit HAS_ARITH  = 1'b1,
  parameter int SEL_W      = (GRP_LINES > 1) ? $clog2(GRP_LINES) : 1
) (
  input  logic [(1<<LUT_INPUTS)-1:0] lut_mask,
  input  logic [1:0]                 cfg_mode,
  input  logic                       cfg_bypass,
  input  logic                       cfg_arith,
  input  logic                       cfg_cascade,
  input  logic [SEL_W-1:0]           cfg_clk_sel,
  input  logic                       cfg_ena_use,
  input  logic [SEL_W-1:0]           cfg_ena_sel,
  input  logic                       cfg_clr_use,
  input  logic [SEL_W-1:0]           cfg_clr_sel,
  input  logic [LUT_INPUTS-1:0]      data_in,
  input  logic                       carry_in,
  input  logic                       cascade_in,
  input  logic [GRP_LINES-1:0]       grp_clk,
  input  logic [GRP_LINES-1:0]       grp_ena,
  input  logic [GRP_LINES-1:0]       grp_clr,
  input  logic                       sync_clr,
  input  logic                       sync_load,
  input  logic                       async_preset,
  input  logic                       async_load,
  input  logic                       rst_n,
  output logic                       cell_out,
  output logic                       carry_out,
  output logic                       cascade_out
);

  localparam int LOAD_IDX = (LUT_INPUTS > 2) ? 2 : LUT_INPUTS - 1;

  // Named internal events, visible to the bound checker.
  logic reg_clk;
  logic ena_eff;
  logic aclr_eff;
  logic aset_eff;
  logic cell_fn;
  logic load_val;
  logic q_reg;

  assign load_val = data_in[LOAD_IDX];

  lc_lut #(
    .LUT_INPUTS (LUT_INPUTS),
    .HAS_ARITH  (HAS_ARITH)
  ) u_lut (
    .lut_mask    (lut_mask),
    .data_in     (data_in),
    .carry_in    (carry_in),
    .cascade_in  (cascade_in),
    .cfg_arith   (cfg_arith),
    .cfg_cascade (cfg_cascade),
    .cell_fn     (cell_fn),
    .carry_out   (carry_out)
  );

  lc_ctrl #(
    .GRP_LINES (GRP_LINES),
    .SEL_W     (SEL_W)
  ) u_ctrl (
    .grp_clk      (grp_clk),
    .grp_ena      (grp_ena),
    .grp_clr      (grp_clr),
    .cfg_clk_sel  (cfg_clk_sel),
    .cfg_ena_use  (cfg_ena_use),
    .cfg_ena_sel  (cfg_ena_sel),
    .cfg_clr_use  (cfg_clr_use),
    .cfg_clr_sel  (cfg_clr_sel),
    .rst_n        (rst_n),
    .async_preset (async_preset),
    .async_load   (async_load),
    .load_val     (load_val),
    .reg_clk      (reg_clk),
    .ena_eff      (ena_eff),
    .aclr_eff     (aclr_eff),
    .aset_eff     (aset_eff)
  );

  lc_storage u_storage (
    .clk       (reg_clk),
    .aclr      (aclr_eff),
    .aset      (aset_eff),
    .sync_clr  (sync_clr),
    .sync_load (sync_load),
    .load_val  (load_val),
    .ena       (ena_eff),
    .mode      (reg_mode_e'(cfg_mode)),
    .x         (cell_fn),
    .j         (data_in[0]),
    .k         (data_in[1]),
    .q         (q_reg)
  );

  assign cell_out    = cfg_bypass ? cell_fn : q_reg;
  assign cascade_out = cell_fn;

endmodule

// File: rtl/lc_checker.sv
`timescale 1ns/1ps
module lc_checker
  import logic_cell_pkg::*;
#(
  parameter int LUT_INPUTS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  q,
  input logic                  aclr_eff,
  input logic                  aset_eff,
  input logic                  sync_clr,
  input logic                  sync_load,
  input logic                  load_val,
  input logic                  ena_eff,
  input logic [1:0]            cfg_mode,
  input logic [LUT_INPUTS-1:0] data_in,
  input logic                  carry_in,
  input logic                  carry_out,
  input logic                  cell_out,
  input logic                  cfg_arith,
  input logic                  cfg_cascade,
  input logic                  cfg_bypass
);

  logic       quiet;
  logic       no_sync;
  logic [1:0] add_ref;

  assign quiet   = !aclr_eff && !aset_eff;
  assign no_sync = !sync_clr && !sync_load;
  assign add_ref = {1'b0, data_in[0]} + {1'b0, data_in[1]} + {1'b0, carry_in};

  a_r2_adder_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_arith && !cfg_cascade && cfg_bypass) |-> ({carry_out, cell_out} == add_ref));

  a_r4_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && no_sync && !ena_eff) |=> ($stable(q) || aclr_eff || aset_eff));

  a_r7_sr_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && no_sync && ena_eff && reg_mode_e'(cfg_mode) == MODE_SR
     && data_in[0] && data_in[1]) |=> ($stable(q) || aclr_eff || aset_eff));

  a_r9_async_clear: assert property (@(posedge clk) disable iff (!rst_n)
    aclr_eff |-> !q);

  a_r10_async_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!aclr_eff && aset_eff) |-> q);

  a_r11_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && sync_clr) |=> (!q || aset_eff));

  a_r12_sync_load: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !sync_clr && sync_load) |=> (q == $past(load_val) || aclr_eff || aset_eff));

endmodule

bind logic_cell lc_checker #(.LUT_INPUTS(LUT_INPUTS)) u_lc_checker (
  .clk         (reg_clk),
  .rst_n       (rst_n),
  .q           (q_reg),
  .aclr_eff    (aclr_eff),
  .aset_eff    (aset_eff),
  .sync_clr    (sync_clr),
  .sync_load   (sync_load),
  .load_val    (load_val),
  .ena_eff     (ena_eff),
  .cfg_mode    (cfg_mode),
  .data_in     (data_in),
  .carry_in    (carry_in),
  .carry_out   (carry_out),
  .cell_out    (cell_out),
  .cfg_arith   (cfg_arith),
  .cfg_cascade (cfg_cascade),
  .cfg_bypass  (cfg_bypass)
);

// File: tb/test_logic_cell.sv
`timescale 1ns/1ps
module test_logic_cell;

  localparam int CLK_PERIOD = 20;
  localparam int WD_CYCLES  = 200000;

  logic [15:0] lut_mask;
  logic [1:0]  cfg_mode;
  logic        cfg_bypass, cfg_arith, cfg_cascade;
  logic        cfg_clk_sel, cfg_ena_use, cfg_ena_sel, cfg_clr_use, cfg_clr_sel;
  logic [3:0]  data_in;
  logic        carry_in, cascade_in;
  logic [1:0]  grp_clk, grp_ena, grp_clr;
  logic        sync_clr, sync_load, async_preset, async_load, rst_n;
  logic        cell_out, carry_out, cascade_out;

  logic ph0 = 1'b0;
  logic ph1 = 1'b0;
  logic en0, en1;
  int   n_checks = 0;
  int   n_fail   = 0;

  // Line 0 rises at 10 mod 20, line 1 at 5 mod 20; stimulus moves at 2 mod 20.
  always #(CLK_PERIOD/2) ph0 = ~ph0;
  initial begin
    #(3*CLK_PERIOD/4);
    forever #(CLK_PERIOD/2) ph1 = ~ph1;
  end
  assign grp_clk = {ph1 & en1, ph0 & en0};

  logic_cell i_logic_cell (
    .lut_mask (lut_mask), .cfg_mode (cfg_mode), .cfg_bypass (cfg_bypass),
    .cfg_arith (cfg_arith), .cfg_cascade (cfg_cascade), .cfg_clk_sel (cfg_clk_sel),
    .cfg_ena_use (cfg_ena_use), .cfg_ena_sel (cfg_ena_sel), .cfg_clr_use (cfg_clr_use),
    .cfg_clr_sel (cfg_clr_sel), .data_in (data_in), .carry_in (carry_in),
    .cascade_in (cascade_in), .grp_clk (grp_clk), .grp_ena (grp_ena), .grp_clr (grp_clr),
    .sync_clr (sync_clr), .sync_load (sync_load), .async_preset (async_preset),
    .async_load (async_load), .rst_n (rst_n), .cell_out (cell_out),
    .carry_out (carry_out), .cascade_out (cascade_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    #(CLK_PERIOD);
  endtask

  task automatic defaults();
    lut_mask = 16'h0000; cfg_mode = 2'd0; cfg_bypass = 0; cfg_arith = 0; cfg_cascade = 0;
    cfg_clk_sel = 0; cfg_ena_use = 0; cfg_ena_sel = 0; cfg_clr_use = 0; cfg_clr_sel = 0;
    data_in = 4'h0; carry_in = 0; cascade_in = 0; grp_ena = 2'b00; grp_clr = 2'b00;
    sync_clr = 0; sync_load = 0; async_preset = 0; async_load = 0; en0 = 1; en1 = 1;
  endtask

  task automatic clear_q();
    sync_clr = 1; tick(); sync_clr = 0;
  endtask

  task automatic test_reset();
    rst_n = 0; #1;
    check("R9 chip reset clears", cell_out, 1'b0);
    #(CLK_PERIOD-1); tick();
    check("R9 reset held through edge", cell_out, 1'b0);
    rst_n = 1;
  endtask

  task automatic test_lut();
    logic [15:0] masks [2];
    masks[0] = 16'hA5C3; masks[1] = 16'h8001;
    defaults(); cfg_bypass = 1;
    for (int m = 0; m < 2; m++) begin
      lut_mask = masks[m];
      for (int i = 0; i < 16; i++) begin
        data_in = 4'(i); #1;
        check("R1 table lookup", cell_out, 1'(masks[m] >> i));
        #(CLK_PERIOD-1);
      end
    end
  endtask

  task automatic test_arith();
    defaults(); cfg_bypass = 1; cfg_arith = 1; lut_mask = 16'hFFFF;
    for (int v = 0; v < 8; v++) begin
      int t;
      data_in[0] = v[0]; data_in[1] = v[1]; carry_in = v[2]; #1;
      t = v[0] + v[1] + v[2];
      check("R2 adder sum", cell_out, t[0]);
      check("R2 adder carry", carry_out, t[1]);
      #(CLK_PERIOD-1);
    end
    cfg_arith = 0; carry_in = 1; #1;
    check("R2 carry passes when not arithmetic", carry_out, 1'b1);
    carry_in = 0; #1;
    check("R2 carry passes low", carry_out, 1'b0);
    #(CLK_PERIOD-2);
  endtask

  task automatic test_cascade();
    defaults(); cfg_bypass = 1; lut_mask = 16'hFFFF; cfg_cascade = 1; cascade_in = 0; #1;
    check("R3 cascade low kills output", cascade_out, 1'b0);
    check("R3 cascade reaches cell_out", cell_out, 1'b0);
    cascade_in = 1; #1;
    check("R3 cascade high passes", cascade_out, 1'b1);
    cfg_cascade = 0; cascade_in = 0; #1;
    check("R3 cascade off ignores cascade_in", cascade_out, 1'b1);
    #(CLK_PERIOD-3);
    cfg_bypass = 0; cfg_cascade = 1; cascade_in = 0; tick();
    check("R3 cascade feeds register low", cell_out, 1'b0);
    cascade_in = 1; tick();
    check("R3 cascade feeds register high", cell_out, 1'b1);
  endtask

  task automatic test_dmode();
    defaults(); lut_mask = 16'hAAAA;
    data_in[0] = 1; tick();
    check("R4 data load one", cell_out, 1'b1);
    data_in[0] = 0; tick();
    check("R4 data load zero", cell_out, 1'b0);
    cfg_ena_use = 1; cfg_ena_sel = 1; grp_ena = 2'b01; data_in[0] = 1; tick();
    check("R4 selected enable low holds", cell_out, 1'b0);
    grp_ena = 2'b10; tick();
    check("R4 selected enable high loads", cell_out, 1'b1);
  endtask

  task automatic test_tmode();
    defaults(); lut_mask = 16'hAAAA; clear_q();
    cfg_mode = 2'd1; data_in[0] = 1; tick();
    check("R5 toggle to one", cell_out, 1'b1);
    tick();
    check("R5 toggle to zero", cell_out, 1'b0);
    tick();
    check("R5 toggle again", cell_out, 1'b1);
    data_in[0] = 0; tick();
    check("R5 function zero holds", cell_out, 1'b1);
  endtask

  task automatic test_jk();
    defaults(); clear_q(); cfg_mode = 2'd2;
    data_in[1:0] = 2'b01; tick(); check("R6 J sets", cell_out, 1'b1);
    data_in[1:0] = 2'b00; tick(); check("R6 none holds", cell_out, 1'b1);
    data_in[1:0] = 2'b10; tick(); check("R6 K clears", cell_out, 1'b0);
    data_in[1:0] = 2'b11; tick(); check("R6 both toggle up", cell_out, 1'b1);
    tick();                       check("R6 both toggle down", cell_out, 1'b0);
  endtask

  task automatic test_sr();
    defaults(); clear_q(); cfg_mode = 2'd3;
    data_in[1:0] = 2'b01; tick(); check("R7 S sets", cell_out, 1'b1);
    data_in[1:0] = 2'b11; tick(); check("R7 both hold one", cell_out, 1'b1);
    data_in[1:0] = 2'b10; tick(); check("R7 R clears", cell_out, 1'b0);
    data_in[1:0] = 2'b11; tick(); check("R7 both hold zero", cell_out, 1'b0);
  endtask

  task automatic test_clksel();
    defaults(); lut_mask = 16'hAAAA; clear_q();
    cfg_clk_sel = 1; en1 = 0; data_in[0] = 1; tick();
    check("R8 unselected clock ignored", cell_out, 1'b0);
    en1 = 1; tick();
    check("R8 selected clock loads", cell_out, 1'b1);
    en0 = 0; data_in[0] = 0; tick();
    check("R8 line one still clocks", cell_out, 1'b0);
    en0 = 1; cfg_clk_sel = 0;
  endtask

  task automatic test_async_clr();
    defaults(); lut_mask = 16'hAAAA; data_in[0] = 1; tick();
    check("R4 setup one", cell_out, 1'b1);
    cfg_clr_use = 1; cfg_clr_sel = 1; grp_clr = 2'b01; #1;
    check("R9 unselected clear ignored", cell_out, 1'b1);
    #(CLK_PERIOD-1);
    grp_clr = 2'b10; #1;
    check("R9 selected clear immediate", cell_out, 1'b0);
    #(CLK_PERIOD-1);
    check("R9 clear held over edge", cell_out, 1'b0);
    grp_clr = 2'b00; tick();
    check("R9 release then load", cell_out, 1'b1);
    cfg_clr_use = 0; grp_clr = 2'b11; #1;
    check("R9 clear disabled ignored", cell_out, 1'b1);
    #(CLK_PERIOD-1);
    grp_clr = 2'b00;
  endtask

  task automatic test_async_set();
    defaults(); lut_mask = 16'hAAAA; tick();
    check("R4 setup zero", cell_out, 1'b0);
    async_preset = 1; #1;
    check("R10 preset immediate", cell_out, 1'b1);
    #(CLK_PERIOD-1);
    async_preset = 0; tick();
    check("R10 preset released", cell_out, 1'b0);
    async_load = 1; data_in[2] = 1; #1;
    check("R10 async load one", cell_out, 1'b1);
    data_in[2] = 0; #1;
    check("R10 async load follows zero", cell_out, 1'b0);
    #(CLK_PERIOD-2);
    async_preset = 1; #1;
    check("R10 preset beats load", cell_out, 1'b1);
    #(CLK_PERIOD-1);
    cfg_clr_use = 1; grp_clr = 2'b01; #1;
    check("R9 clear beats preset", cell_out, 1'b0);
    #(CLK_PERIOD-1);
    async_preset = 0; async_load = 0; grp_clr = 2'b00; cfg_clr_use = 0; tick();
  endtask

  task automatic test_sync();
    defaults(); lut_mask = 16'hAAAA; clear_q();
    cfg_ena_use = 1; grp_ena = 2'b00; data_in[0] = 1;
    sync_load = 1; data_in[2] = 1; tick();
    check("R12 sync load with enable low", cell_out, 1'b1);
    data_in[2] = 0; tick();
    check("R12 sync load zero", cell_out, 1'b0);
    data_in[2] = 1; sync_clr = 1; tick();
    check("R11 clear beats load", cell_out, 1'b0);
    sync_clr = 0; sync_load = 0; tick();
    check("R4 enable low holds", cell_out, 1'b0);
    sync_load = 1; tick(); sync_load = 0; sync_clr = 1; tick();
    check("R11 sync clear with enable low", cell_out, 1'b0);
    sync_clr = 0; grp_ena = 2'b01; data_in[0] = 0; sync_load = 1; tick();
    check("R12 load beats mode update", cell_out, 1'b1);
    sync_load = 0; tick();
    check("R4 mode update resumes", cell_out, 1'b0);
  endtask

  task automatic test_bypass();
    defaults(); clear_q(); cfg_ena_use = 1; lut_mask = 16'hFFFF; #1;
    check("R13 registered path shows stored bit", cell_out, 1'b0);
    cfg_bypass = 1; #1;
    check("R13 bypass shows function at once", cell_out, 1'b1);
    #(CLK_PERIOD-2);
  endtask

  initial begin
    #(CLK_PERIOD*WD_CYCLES);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    defaults(); rst_n = 1;
    #2;
    test_reset();
    test_lut();
    test_arith();
    test_cascade();
    test_dmode();
    test_tmode();
    test_jk();
    test_sr();
    test_clksel();
    test_async_clr();
    test_async_set();
    test_sync();
    test_bypass();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule